// File: doc/BRIEF.md
# Release Ring Consumer

This block is the hardware end of an eight-slot circular ring. Software uses the ring to return freed buffers to a buffer pool manager. Software fills a slot in a local store through a simple write port. It writes the buffer words first and the slot's command byte last. The block watches the slot at its consumer position. It takes the slot only when the valid bit in the command byte shows the phase of the current pass around the ring. That phase flips every time the consumer index wraps from slot 7 back to slot 0. Because of this, software never has to write a producer index to announce new work.

For every slot it accepts, the block decodes a pool number and a buffer count. It then streams the buffer addresses, one per handshake, to a pool sink. After the last address has been taken, it moves the consumer index forward. Software can read the index, with its phase bit, at a port. A slot whose command byte is malformed is stepped over and flagged. A counter of finished slots, compared against a threshold set by software, drives an interrupt line.

Top module: `relring_consumer`

## Requirements
- R1: After a synchronous active-low reset, the consumer index is 0 with phase bit 0, `out_valid` is low, `err_sticky` is low and `irq` is low.
- R2: A slot is new only when bit 7 of its command byte differs from bit 3 of the consumer index. Any other slot produces no output and leaves the index unchanged.
- R3: Buffers are sent in word order 0 to count-1. Each beat carries bits 47:0 of the buffer word on `out_addr`, and bits 63:48 of word 0 on `out_pool` for every beat of that slot.
- R4: The count field, bits 3:0 of the command byte, sets the number of beats. Any value from 1 to 8 gives exactly that many transfers.
- R5: The 4-bit consumer index (slot in bits 2:0, phase in bit 3) increases by one only when the last beat of a slot is accepted or when a bad slot is dropped. Going from slot 7 to slot 0 toggles the phase bit.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` and `out_pool` hold their values.
- R7: A new slot whose count is 0 or greater than 8 produces no beats. It advances the index and sets `err_sticky`, which then stays set until reset.
- R8: A new slot whose command code (bits 6:4) is not 3'b001 is handled the same way as in R7.
- R9: Each slot that is finished or dropped adds one to a saturating counter, which `irq_clr` clears to zero. `irq` is high exactly when `irq_thresh` is nonzero and the counter is at least `irq_thresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Store write strobe |
| sw_wr_slot | input | 3 | Slot being written |
| sw_wr_word | input | 4 | Word select: 0-7 buffer words, 8 command byte |
| sw_wr_data | input | 64 | Write data (command byte in bits 7:0) |
| out_valid | output | 1 | Buffer beat valid |
| out_ready | input | 1 | Sink accepts beat |
| out_pool | output | 16 | Pool number of the current slot |
| out_addr | output | 48 | Buffer address |
| ci_out | output | 4 | Consumer index with phase bit |
| err_sticky | output | 1 | A malformed slot has been seen |
| irq_thresh | input | 4 | Finished-slot threshold, 0 disables |
| irq_clr | input | 1 | Clears the finished-slot counter |
| irq | output | 1 | Threshold reached |

## Verification
A wrong expected phase shows up at once in one of two ways. Either the block stalls with `ci_out` frozen while a fresh slot waits, or it replays a stale slot, which appears as an extra burst of beats on the sink. A wrong beat counter or wrong word select shows as a missing, extra or reordered address within the same slot's burst, a few cycles after the command byte lands. A wrong index step is seen at `ci_out` on the cycle after the last beat, and it throws off the phase of every later pass.

// File: rtl/relring_pkg.sv
package relring_pkg;
    // Command byte field positions and the release code
    localparam int          VB_BIT      = 7;
    localparam int          CNT_FW      = 4;
    localparam logic [2:0]  CMD_RELEASE = 3'b001;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } drain_state_t;
endpackage

// File: rtl/relring_store.sv
// Slot store: buffer words and command bytes written by software.
// Assumes the command byte is written after the buffer words of a slot.
// Command bytes reset to zero; buffer words are not reset.
module relring_store #(
    parameter int SLOTS     = 8,
    parameter int BUFS      = 8,
    parameter int WORD_BITS = 64,
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int KW       = $clog2(BUFS),
    localparam int WORD_W   = KW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_slot,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic [IDX_W-1:0]     rd_slot,
    input  logic [KW-1:0]        rd_word,
    output logic [7:0]           rd_verb,
    output logic [WORD_BITS-1:0] rd_data,
    output logic [WORD_BITS-1:0] rd_word0
);
    localparam logic [WORD_W-1:0] VERB_SEL = WORD_W'(BUFS);

    logic [WORD_BITS-1:0] mem  [SLOTS][BUFS];
    logic [7:0]           verb [SLOTS];

    // Buffer word writes
    always_ff @(posedge clk) begin
        if (wr_en && !wr_word[KW]) begin
            mem[wr_slot][wr_word[KW-1:0]] <= wr_data;
        end
    end

    // Command byte writes with reset to the empty pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) verb[s] <= '0;
        end else if (wr_en && wr_word == VERB_SEL) begin
            verb[wr_slot] <= wr_data[7:0];
        end
    end

    // Combinational read of the consumer's slot
    always_comb begin
        rd_verb  = verb[rd_slot];
        rd_data  = mem[rd_slot][rd_word];
        rd_word0 = mem[rd_slot][0];
    end
endmodule

// File: rtl/relring_verb_dec.sv
// Command byte decoder: newness against the consumer phase and well-formedness.
// Assumes the count field occupies bits 3:0 and the code bits 6:4.
module relring_verb_dec
    import relring_pkg::*;
#(
    parameter int BUFS = 8
) (
    input  logic              phase,
    input  logic [7:0]        verb,
    output logic              is_new,
    output logic              is_good,
    output logic [CNT_FW-1:0] count
);
    localparam logic [CNT_FW-1:0] MAXC = CNT_FW'(BUFS);

    // Split and qualify the command byte
    always_comb begin
        count   = verb[CNT_FW-1:0];
        is_new  = verb[VB_BIT] != phase;
        is_good = (verb[6:4] == CMD_RELEASE) && (count != '0) && (count <= MAXC);
    end
endmodule

// File: rtl/relring_drain.sv
// Drain engine: takes new slots at the consumer index, emits their buffers
// one per handshake, drops malformed slots and advances the index.
// Assumes SLOTS is a power of two so the index carry is the phase bit.
module relring_drain
    import relring_pkg::*;
#(
    parameter int SLOTS     = 8,
    parameter int BUFS      = 8,
    parameter int WORD_BITS = 64,
    parameter int ADDR_W    = 48,
    parameter int POOL_W    = 16,
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int KW       = $clog2(BUFS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 is_new,
    input  logic                 is_good,
    input  logic [CNT_FW-1:0]    count,
    input  logic [WORD_BITS-1:0] rd_data,
    input  logic [WORD_BITS-1:0] rd_word0,
    input  logic                 out_ready,
    output logic [KW-1:0]        rd_word,
    output logic [IDX_W:0]       ci,
    output logic                 out_valid,
    output logic [POOL_W-1:0]    out_pool,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 err,
    output logic                 slot_done
);
    drain_state_t      st;
    logic [KW-1:0]     beat;
    logic [KW-1:0]     last;
    logic [POOL_W-1:0] pool_q;
    logic [CNT_FW-1:0] cnt_m1;

    assign cnt_m1 = count - 1'b1;

    // Slot intake, beat stepping and index advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            beat   <= '0;
            last   <= '0;
            pool_q <= '0;
            ci     <= '0;
            err    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (is_new) begin
                        if (is_good) begin
                            st     <= ST_EMIT;
                            beat   <= '0;
                            last   <= cnt_m1[KW-1:0];
                            pool_q <= rd_word0[WORD_BITS-1 -: POOL_W];
                        end else begin
                            ci  <= ci + 1'b1;
                            err <= 1'b1;
                        end
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (beat == last) begin
                            ci <= ci + 1'b1;
                            st <= ST_IDLE;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output beat and completion pulse
    always_comb begin
        out_valid = (st == ST_EMIT);
        out_pool  = pool_q;
        out_addr  = rd_data[ADDR_W-1:0];
        rd_word   = beat;
        slot_done = ((st == ST_IDLE) && is_new && !is_good) ||
                    ((st == ST_EMIT) && out_ready && (beat == last));
    end
endmodule

// File: rtl/relring_irq.sv
// Finished-slot counter and threshold compare for the interrupt line.
// Clear has priority over a simultaneous completion.
module relring_irq #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_done,
    input  logic             clr,
    input  logic [CNT_W-1:0] thresh,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    logic [CNT_W-1:0] done_cnt;

    // Saturating count of finished slots
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            done_cnt <= '0;
        end else if (slot_done && done_cnt != CMAX) begin
            done_cnt <= done_cnt + 1'b1;
        end
    end

    // Threshold compare
    assign irq = (thresh != '0) && (done_cnt >= thresh);
endmodule

// File: rtl/relring_consumer.sv
// Top: valid-bit release ring consumer. Software writes slots through the
// store port; the drain engine streams buffer addresses to the pool sink.
module relring_consumer #(
    parameter int SLOTS     = 8,
    parameter int BUFS      = 8,
    parameter int WORD_BITS = 64,
    parameter int ADDR_W    = 48,
    parameter int POOL_W    = 16,
    parameter int CNT_W     = 4,
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int KW       = $clog2(BUFS),
    localparam int WORD_W   = KW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_wr_en,
    input  logic [IDX_W-1:0]     sw_wr_slot,
    input  logic [WORD_W-1:0]    sw_wr_word,
    input  logic [WORD_BITS-1:0] sw_wr_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [POOL_W-1:0]    out_pool,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [IDX_W:0]       ci_out,
    output logic                 err_sticky,
    input  logic [CNT_W-1:0]     irq_thresh,
    input  logic                 irq_clr,
    output logic                 irq
);
    logic [7:0]                  verb;
    logic [WORD_BITS-1:0]        rd_data;
    logic [WORD_BITS-1:0]        rd_word0;
    logic [KW-1:0]               rd_word;
    logic                        is_new;
    logic                        is_good;
    logic [relring_pkg::CNT_FW-1:0] count;
    logic                        slot_done;

    relring_store #(.SLOTS(SLOTS), .BUFS(BUFS), .WORD_BITS(WORD_BITS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(sw_wr_en), .wr_slot(sw_wr_slot), .wr_word(sw_wr_word), .wr_data(sw_wr_data),
        .rd_slot(ci_out[IDX_W-1:0]), .rd_word(rd_word),
        .rd_verb(verb), .rd_data(rd_data), .rd_word0(rd_word0)
    );

    relring_verb_dec #(.BUFS(BUFS)) u_dec (
        .phase(ci_out[IDX_W]), .verb(verb),
        .is_new(is_new), .is_good(is_good), .count(count)
    );

    relring_drain #(.SLOTS(SLOTS), .BUFS(BUFS), .WORD_BITS(WORD_BITS),
                    .ADDR_W(ADDR_W), .POOL_W(POOL_W)) u_drain (
        .clk(clk), .rst_n(rst_n),
        .is_new(is_new), .is_good(is_good), .count(count),
        .rd_data(rd_data), .rd_word0(rd_word0), .out_ready(out_ready),
        .rd_word(rd_word), .ci(ci_out),
        .out_valid(out_valid), .out_pool(out_pool), .out_addr(out_addr),
        .err(err_sticky), .slot_done(slot_done)
    );

    relring_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .slot_done(slot_done),
        .clr(irq_clr), .thresh(irq_thresh), .irq(irq)
    );
endmodule

// File: rtl/relring_checker.sv
// Property checker for relring_consumer, attached by bind.
module relring_checker #(
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 48,
    parameter int POOL_W = 16,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [POOL_W-1:0] out_pool,
    input logic [ADDR_W-1:0] out_addr,
    input logic [IDX_W:0]    ci_out,
    input logic              err_sticky,
    input logic [CNT_W-1:0]  irq_thresh,
    input logic              irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ci_out == '0 && !out_valid && !err_sticky));

    // R6
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_pool)));

    // R5
    index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ci_out != $past(ci_out)) |-> (ci_out == $past(ci_out) + 1'b1));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(err_sticky)) |-> err_sticky);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_thresh != '0));
endmodule

bind relring_consumer relring_checker #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .POOL_W(POOL_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_pool(out_pool), .out_addr(out_addr), .ci_out(ci_out),
    .err_sticky(err_sticky), .irq_thresh(irq_thresh), .irq(irq)
);

// File: tb/relring_consumer_bench.sv
`timescale 1ns/1ps
module relring_consumer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [2:0]  sw_wr_slot = '0;
    logic [3:0]  sw_wr_word = '0;
    logic [63:0] sw_wr_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_pool;
    logic [47:0] out_addr;
    logic [3:0]  ci_out;
    logic        err_sticky;
    logic [3:0]  irq_thresh = '0;
    logic        irq_clr = 1'b0;
    logic        irq;

    int checks = 0;
    int bad = 0;
    bit done_flag = 0;
    logic [3:0] exp_ci = '0;

    logic [15:0] cap_pool[$];
    logic [47:0] cap_addr[$];

    localparam int NV = 10;
    localparam logic [15:0] V_POOL [NV] = '{16'h0011, 16'h0022, 16'h0033, 16'h0044, 16'h0055,
                                           16'h0066, 16'h0077, 16'h0088, 16'h0099, 16'h00AA};
    localparam logic [3:0]  V_CNT  [NV] = '{4'd1, 4'd8, 4'd3, 4'd5, 4'd2, 4'd7, 4'd4, 4'd6, 4'd1, 4'd8};
    localparam logic [31:0] V_BASE [NV] = '{32'h1000_0000, 32'h2000_0040, 32'h3000_0080, 32'h4000_00C0,
                                           32'h5000_0100, 32'h6000_0140, 32'h7000_0180, 32'h8000_01C0,
                                           32'h9000_0200, 32'hA000_0240};

    relring_consumer u_relring_consumer (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_slot(sw_wr_slot),
        .sw_wr_word(sw_wr_word), .sw_wr_data(sw_wr_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_pool(out_pool), .out_addr(out_addr), .ci_out(ci_out),
        .err_sticky(err_sticky), .irq_thresh(irq_thresh), .irq_clr(irq_clr), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Record accepted beats away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            cap_pool.push_back(out_pool);
            cap_addr.push_back(out_addr);
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [2:0] slot, input logic [3:0] word, input logic [63:0] data);
        @(posedge clk); #1;
        sw_wr_en = 1'b1; sw_wr_slot = slot; sw_wr_word = word; sw_wr_data = data;
        @(posedge clk); #1;
        sw_wr_en = 1'b0;
    endtask

    // Command byte with the valid bit a new slot needs at the expected index
    function automatic logic [7:0] mk_verb(input logic [2:0] code, input logic [3:0] cnt);
        return {~exp_ci[3], code, cnt};
    endfunction

    // Addresses carry junk above bit 47 on words 1..7, pool on word 0
    function automatic logic [47:0] addr_of(input logic [31:0] base, input int k);
        return {16'h00C0, base} + 48'(k * 32'h1000);
    endfunction

    task automatic fill_slot(input logic [15:0] pool, input logic [3:0] cnt, input logic [31:0] base,
                             input logic [2:0] code);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] top;
            top = (k == 0) ? pool : 16'hA5A5;
            wr(exp_ci[2:0], 4'(k), {top, addr_of(base, k)});
        end
        wr(exp_ci[2:0], 4'd8, {56'd0, mk_verb(code, cnt)});
    endtask

    task automatic wait_ci(input logic [3:0] target);
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (ci_out == target) break;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ci_out == 4'd0, "R1 ci", 64'(ci_out), 0);
        check(!out_valid, "R1 valid", 64'(out_valid), 0);
        check(!err_sticky, "R1 err", 64'(err_sticky), 0);
        check(!irq, "R1 irq", 64'(irq), 0);

        // R2 stale valid bit (equal to phase 0) is ignored
        wr(3'd0, 4'd0, 64'h0011_0000_0000_1234);
        wr(3'd0, 4'd8, {56'd0, 1'b0, 3'b001, 4'd1});
        repeat (10) @(negedge clk);
        check(ci_out == 4'd0, "R2 ci held", 64'(ci_out), 0);
        check(cap_addr.size() == 0, "R2 no beats", 64'(cap_addr.size()), 0);

        // R3 R4 R5 vector walk across a wrap
        for (int i = 0; i < NV; i++) begin
            cap_addr.delete(); cap_pool.delete();
            fill_slot(V_POOL[i], V_CNT[i], V_BASE[i], 3'b001);
            exp_ci = exp_ci + 1'b1;
            wait_ci(exp_ci);
            check(ci_out == exp_ci, "R5 index", 64'(ci_out), 64'(exp_ci));
            check(cap_addr.size() == int'(V_CNT[i]), "R4 beat count", 64'(cap_addr.size()), 64'(V_CNT[i]));
            for (int k = 0; k < int'(V_CNT[i]) && k < cap_addr.size(); k++) begin
                check(cap_addr[k] == addr_of(V_BASE[i], k), "R3 addr", 64'(cap_addr[k]), 64'(addr_of(V_BASE[i], k)));
                check(cap_pool[k] == V_POOL[i], "R3 pool", 64'(cap_pool[k]), 64'(V_POOL[i]));
            end
        end

        // R6 stall holds the beat; index waits for the last beat
        cap_addr.delete(); cap_pool.delete();
        @(posedge clk); #1 out_ready = 1'b0;
        fill_slot(16'h0BB0, 4'd2, 32'hB000_0000, 3'b001);
        repeat (4) @(negedge clk);
        check(out_valid, "R6 valid held", 64'(out_valid), 1);
        check(out_addr == addr_of(32'hB000_0000, 0), "R6 addr held", 64'(out_addr), 64'(addr_of(32'hB000_0000, 0)));
        check(ci_out == exp_ci, "R5 no early advance", 64'(ci_out), 64'(exp_ci));
        @(posedge clk); #1 out_ready = 1'b1;
        exp_ci = exp_ci + 1'b1;
        wait_ci(exp_ci);
        check(ci_out == exp_ci, "R5 after stall", 64'(ci_out), 64'(exp_ci));
        check(cap_addr.size() == 2, "R6 beats after stall", 64'(cap_addr.size()), 2);

        // R7 count 0 and count 9, R8 bad code
        cap_addr.delete();
        check(!err_sticky, "R7 err clear before", 64'(err_sticky), 0);
        fill_slot(16'h0C00, 4'd0, 32'hC000_0000, 3'b001);
        exp_ci = exp_ci + 1'b1;
        wait_ci(exp_ci);
        check(ci_out == exp_ci, "R7 count0 consumed", 64'(ci_out), 64'(exp_ci));
        check(err_sticky, "R7 err set", 64'(err_sticky), 1);
        fill_slot(16'h0C01, 4'd9, 32'hC100_0000, 3'b001);
        exp_ci = exp_ci + 1'b1;
        wait_ci(exp_ci);
        check(ci_out == exp_ci, "R7 count9 consumed", 64'(ci_out), 64'(exp_ci));
        fill_slot(16'h0C02, 4'd2, 32'hC200_0000, 3'b010);
        exp_ci = exp_ci + 1'b1;
        wait_ci(exp_ci);
        check(ci_out == exp_ci, "R8 bad code consumed", 64'(ci_out), 64'(exp_ci));
        check(cap_addr.size() == 0, "R7 R8 no beats", 64'(cap_addr.size()), 0);
        check(err_sticky, "R7 err sticky", 64'(err_sticky), 1);

        // R9 threshold interrupt
        @(posedge clk); #1 irq_clr = 1'b1; irq_thresh = 4'd2;
        @(posedge clk); #1 irq_clr = 1'b0;
        @(negedge clk);
        check(!irq, "R9 cleared", 64'(irq), 0);
        fill_slot(16'h0D00, 4'd1, 32'hD000_0000, 3'b001);
        exp_ci = exp_ci + 1'b1;
        wait_ci(exp_ci);
        check(!irq, "R9 below thresh", 64'(irq), 0);
        fill_slot(16'h0D01, 4'd3, 32'hD100_0000, 3'b001);
        exp_ci = exp_ci + 1'b1;
        wait_ci(exp_ci);
        check(irq, "R9 at thresh", 64'(irq), 1);
        @(posedge clk); #1 irq_thresh = 4'd0;
        @(negedge clk);
        check(!irq, "R9 disabled", 64'(irq), 0);
        @(posedge clk); #1 irq_thresh = 4'd2; irq_clr = 1'b1;
        @(posedge clk); #1 irq_clr = 1'b0;
        @(negedge clk);
        check(!irq, "R9 clear drops irq", 64'(irq), 0);

        finish_run();
    end
endmodule